// File: doc/BRIEF.md
# Fenced Cache-Line Write Issuer

This engine sits on the accelerator side of a host link and turns one command into a stream of cache-line write requests toward host memory. A command gives a base line address, a number of lines, a group size and a virtual-channel choice. The engine sends the lines in address order. Between every two consecutive groups it places a write-fence request, so that the host completes all writes of one group before any write of the next. It then counts write completions and fence responses that come back on the write-response channel. It reports done once every request it sent has been acknowledged.

The host side raises an almost-full flag while it can still take eight more requests. The engine removes its request valid in the same cycle that it sees the flag high, so it never relies on that slack. It resumes in the first cycle the flag is seen low. A fence can be limited to the command's own virtual channel, or it can cover every channel.

Top module: `fwr_engine`

## Requirements
- R1: After reset `tx_valid`, `busy` and `done` are low and `cmd_ready` is high.
- R2: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly when the engine is idle or done. A command offered while the engine is busy has no effect on the request stream. A taken command with a nonzero line count makes `busy` high in the next cycle.
- R3: The header is `{kind[1:0], vc[1:0], tag[TW-1:0], addr[AW-1:0]}`, most significant field first. The k-th write (k counting from 0) carries kind 2'b01, address `base+k` modulo 2^AW, tag `k` modulo 2^TW, and data equal to the zero-extended address.
- R4: A fence (kind 2'b10, address 0, data 0, tag = the fence's ordinal from 0 modulo 2^TW) is sent after every `cmd_group` writes, and only when more writes of the command remain. No fence follows the last write. A group size of 0, or a group size not smaller than the line count, gives no fences.
- R5: Writes carry `cmd_vc` in the vc field. Fences carry 2'b00 (all channels) when `cmd_all_vc` is 1, and `cmd_vc` otherwise.
- R6: `tx_valid` is low in every cycle where `tx_almost_full` is high. It is high in every cycle where `tx_almost_full` is low and requests of the current command remain to be sent. Every cycle with `tx_valid` high sends one request.
- R7: `done` is high only after all requests of the command have been sent and every write completion (`rx_fence`=0) and every fence response (`rx_fence`=1) has been received. It then holds until the next command is taken. A command of zero lines gives `done` in the cycle after it is taken.
- R8: Write completions may arrive in any order within a group and interleaved with fence responses. The engine counts the two kinds separately and neither raises `done` early nor holds it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_base | input | AW | First cache-line address |
| cmd_lines | input | CW | Number of lines to write |
| cmd_group | input | CW | Writes per group (0: no fences) |
| cmd_vc | input | 2 | Virtual-channel select for the command |
| cmd_all_vc | input | 1 | Fences cover all channels |
| tx_almost_full | input | 1 | Host can take only a few more requests |
| tx_valid | output | 1 | Request sent this cycle |
| tx_hdr | output | 4+TW+AW | Request header |
| tx_data | output | DW | Line payload (zero for fences) |
| rx_valid | input | 1 | Response on the write-response channel |
| rx_fence | input | 1 | Response is a fence response (else a write completion) |
| busy | output | 1 | Command in progress and not done |
| done | output | 1 | All requests of the command acknowledged |

## Verification
The bench drives almost-full at several densities and checks that valid drops in the very cycle the flag is high and returns in the first free cycle. A design that ignored the flag, or stalled one cycle too long, would break the exact valid check. Commands whose line count is an exact multiple of the group size are there to catch a stray trailing fence. Group sizes of 0, 1 and larger than the count, a zero-line command, an address that wraps and tags that wrap cover the edges of the counters. The host model returns writes within a group in random order and holds each fence response back until the earlier writes are done. A tracker that mixed the two response kinds, or that compared the wrong counters, would raise done early or never.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

    typedef enum logic [1:0] {
        REQ_NONE    = 2'b00,
        REQ_WRLINE  = 2'b01,
        REQ_WRFENCE = 2'b10
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_DRAIN = 2'b10
    } seq_state_e;

    localparam logic [1:0] VC_ANY = 2'b00;

    function automatic logic [1:0] fence_scope(input logic [1:0] vc, input logic all_ch);
        return all_ch ? VC_ANY : vc;
    endfunction

endpackage

// File: rtl/fwr_seq.sv
module fwr_seq
    import fwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 10,
    parameter int TW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [AW-1:0]   cmd_base,
    input  logic [CW-1:0]   cmd_lines,
    input  logic [CW-1:0]   cmd_group,
    input  logic [1:0]      cmd_vc,
    input  logic            cmd_all_vc,
    input  logic            balanced,
    input  logic            tx_almost_full,
    output logic            cmd_ready,
    output logic            cmd_take,
    output logic            running,
    output logic            draining,
    output logic            beat_valid,
    output req_kind_e       beat_kind,
    output logic [1:0]      beat_vc,
    output logic [TW-1:0]   beat_tag,
    output logic [AW-1:0]   beat_addr
);

    localparam int CXW = CW + 1;

    seq_state_e      st;
    logic [AW-1:0]   base_q;
    logic [CW-1:0]   lines_q;
    logic [CW-1:0]   group_q;
    logic [1:0]      vc_q;
    logic            all_q;
    logic [CW-1:0]   wr_idx;
    logic [CW-1:0]   grp_cnt;
    logic [TW-1:0]   fence_idx;
    logic            fence_due;
    logic            last_wr;

    assign running   = (st == ST_RUN);
    assign draining  = (st == ST_DRAIN);
    assign cmd_ready = (st == ST_IDLE) || (draining && balanced);
    assign cmd_take  = cmd_valid && cmd_ready;

    // a fence is due once a full group has gone out; the run ends on a write,
    // so a fence is never the final request
    assign fence_due = (group_q != '0) && (grp_cnt == group_q);
    assign last_wr   = (CXW'(wr_idx) + CXW'(1)) == CXW'(lines_q);

    // stop in the very cycle almost-full is seen high
    assign beat_valid = running && !tx_almost_full;

    always_comb begin
        if (fence_due) begin
            beat_kind = REQ_WRFENCE;
            beat_vc   = fence_scope(vc_q, all_q);
            beat_tag  = fence_idx;
            beat_addr = '0;
        end else begin
            beat_kind = REQ_WRLINE;
            beat_vc   = vc_q;
            beat_tag  = TW'(wr_idx);
            beat_addr = base_q + AW'(wr_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            base_q    <= '0;
            lines_q   <= '0;
            group_q   <= '0;
            vc_q      <= '0;
            all_q     <= 1'b0;
            wr_idx    <= '0;
            grp_cnt   <= '0;
            fence_idx <= '0;
        end else if (cmd_take) begin
            base_q    <= cmd_base;
            lines_q   <= cmd_lines;
            group_q   <= cmd_group;
            vc_q      <= cmd_vc;
            all_q     <= cmd_all_vc;
            wr_idx    <= '0;
            grp_cnt   <= '0;
            fence_idx <= '0;
            st        <= (cmd_lines == '0) ? ST_DRAIN : ST_RUN;
        end else if (beat_valid) begin
            if (fence_due) begin
                grp_cnt   <= '0;
                fence_idx <= fence_idx + TW'(1);
            end else begin
                wr_idx  <= wr_idx + CW'(1);
                grp_cnt <= grp_cnt + CW'(1);
                if (last_wr) begin
                    st <= ST_DRAIN;
                end
            end
        end
    end

    // R4: a fence never precedes the first write of a command
    assert_fence_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_kind == REQ_WRFENCE) |-> (wr_idx != '0));

    // R4: entering the drain phase from a run always follows a write
    assert_run_ends_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(draining) && !$past(cmd_take)) |-> ($past(beat_kind) == REQ_WRLINE && $past(beat_valid)));

endmodule

// File: rtl/fwr_track.sv
module fwr_track #(
    parameter int CW = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic wr_sent,
    input  logic fence_sent,
    input  logic rx_valid,
    input  logic rx_fence,
    input  logic tx_almost_full,
    output logic balanced
);

    logic [CW-1:0] wr_issued;
    logic [CW-1:0] wr_done;
    logic [CW-1:0] fence_open;
    logic          fence_back;
    logic          wr_back;

    assign fence_back = rx_valid && rx_fence;
    assign wr_back    = rx_valid && !rx_fence;
    assign balanced   = (wr_issued == wr_done) && (fence_open == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_issued  <= '0;
            wr_done    <= '0;
            fence_open <= '0;
        end else begin
            if (wr_sent) begin
                wr_issued <= wr_issued + CW'(1);
            end
            if (wr_back) begin
                wr_done <= wr_done + CW'(1);
            end
            case ({fence_sent, fence_back})
                2'b10:   fence_open <= fence_open + CW'(1);
                2'b01:   fence_open <= fence_open - CW'(1);
                default: fence_open <= fence_open;
            endcase
        end
    end

    // R6: nothing is counted as sent across a cycle with almost-full high
    assert_hold_on_full_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_almost_full && !clear) |=> $stable(wr_issued));

    // R8: a write completion never exceeds the writes sent
    assert_no_extra_wr_R8: assert property (@(posedge clk) disable iff (rst)
        wr_back |-> (wr_done != wr_issued));

    // R8: a fence response always matches an open fence
    assert_no_extra_fence_R8: assert property (@(posedge clk) disable iff (rst)
        fence_back |-> (fence_open != '0));

endmodule

// File: rtl/fwr_hdr.sv
module fwr_hdr
    import fwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 8,
    parameter int DW = 512,
    parameter int HW = 4 + TW + AW
) (
    input  req_kind_e       kind,
    input  logic [1:0]      vc,
    input  logic [TW-1:0]   tag,
    input  logic [AW-1:0]   addr,
    output logic [HW-1:0]   hdr,
    output logic [DW-1:0]   data
);

    logic [DW-1:0] line_word;

    assign hdr = {kind, vc, tag, addr};

    generate
        if (DW > AW) begin : g_pad
            assign line_word = {{(DW - AW){1'b0}}, addr};
        end else begin : g_trunc
            assign line_word = addr[DW-1:0];
        end
    endgenerate

    assign data = (kind == REQ_WRLINE) ? line_word : '0;

endmodule

// File: rtl/fwr_engine.sv
module fwr_engine
    import fwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 10,
    parameter int TW = 8,
    parameter int DW = 512,
    localparam int HW = 4 + TW + AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [AW-1:0]   cmd_base,
    input  logic [CW-1:0]   cmd_lines,
    input  logic [CW-1:0]   cmd_group,
    input  logic [1:0]      cmd_vc,
    input  logic            cmd_all_vc,
    input  logic            tx_almost_full,
    output logic            tx_valid,
    output logic [HW-1:0]   tx_hdr,
    output logic [DW-1:0]   tx_data,
    input  logic            rx_valid,
    input  logic            rx_fence,
    output logic            busy,
    output logic            done
);

    logic          cmd_take;
    logic          running;
    logic          draining;
    logic          balanced;
    req_kind_e     beat_kind;
    logic [1:0]    beat_vc;
    logic [TW-1:0] beat_tag;
    logic [AW-1:0] beat_addr;

    fwr_seq #(.AW(AW), .CW(CW), .TW(TW)) i_seq (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_base       (cmd_base),
        .cmd_lines      (cmd_lines),
        .cmd_group      (cmd_group),
        .cmd_vc         (cmd_vc),
        .cmd_all_vc     (cmd_all_vc),
        .balanced       (balanced),
        .tx_almost_full (tx_almost_full),
        .cmd_ready      (cmd_ready),
        .cmd_take       (cmd_take),
        .running        (running),
        .draining       (draining),
        .beat_valid     (tx_valid),
        .beat_kind      (beat_kind),
        .beat_vc        (beat_vc),
        .beat_tag       (beat_tag),
        .beat_addr      (beat_addr)
    );

    fwr_track #(.CW(CW)) i_track (
        .clk            (clk),
        .rst            (rst),
        .clear          (cmd_take),
        .wr_sent        (tx_valid && beat_kind == REQ_WRLINE),
        .fence_sent     (tx_valid && beat_kind == REQ_WRFENCE),
        .rx_valid       (rx_valid),
        .rx_fence       (rx_fence),
        .tx_almost_full (tx_almost_full),
        .balanced       (balanced)
    );

    fwr_hdr #(.AW(AW), .TW(TW), .DW(DW), .HW(HW)) i_hdr (
        .kind (beat_kind),
        .vc   (beat_vc),
        .tag  (beat_tag),
        .addr (beat_addr),
        .hdr  (tx_hdr),
        .data (tx_data)
    );

    assign done = draining && balanced;
    assign busy = (running || draining) && !done;

    // address continuity watch for the write stream
    logic          prev_ok;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst || cmd_take) begin
            prev_ok   <= 1'b0;
            prev_addr <= '0;
        end else if (tx_valid && tx_hdr[HW-1 -: 2] == REQ_WRLINE) begin
            prev_ok   <= 1'b1;
            prev_addr <= tx_hdr[AW-1:0];
        end
    end

    // R3: consecutive writes of a command step the line address by one
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_hdr[HW-1 -: 2] == REQ_WRLINE && prev_ok) |-> (tx_hdr[AW-1:0] == prev_addr + AW'(1)));

    // R2: a taken nonempty command leaves the engine busy
    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_lines != '0) |=> busy);

    // R7: done holds until a new command arrives
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_valid) |=> done);

endmodule

// File: tb/test_fwr_engine.sv
`timescale 1ns/1ps
module test_fwr_engine;

    localparam int AW = 32;
    localparam int CW = 10;
    localparam int TW = 8;
    localparam int DW = 512;
    localparam int HW = 4 + TW + AW;
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_base = '0;
    logic [CW-1:0] cmd_lines = '0;
    logic [CW-1:0] cmd_group = '0;
    logic [1:0]    cmd_vc = '0;
    logic          cmd_all_vc = 1'b0;
    logic          tx_almost_full = 1'b0;
    logic          tx_valid;
    logic [HW-1:0] tx_hdr;
    logic [DW-1:0] tx_data;
    logic          rx_valid = 1'b0;
    logic          rx_fence = 1'b0;
    logic          busy;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;
    bit pend[$];

    always #2 clk = ~clk;

    fwr_engine #(.AW(AW), .CW(CW), .TW(TW), .DW(DW)) i_fwr_engine (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
        .cmd_lines(cmd_lines), .cmd_group(cmd_group), .cmd_vc(cmd_vc), .cmd_all_vc(cmd_all_vc),
        .tx_almost_full(tx_almost_full), .tx_valid(tx_valid), .tx_hdr(tx_hdr), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_fence(rx_fence), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [HW-1:0] exp_write(input logic [AW-1:0] base, input int k, input logic [1:0] vc);
        logic [AW-1:0] a;
        a = base + AW'(k);
        return {2'b01, vc, TW'(k), a};
    endfunction

    function automatic logic [HW-1:0] exp_fence(input int f, input logic [1:0] vc, input bit allc);
        return {2'b10, (allc ? 2'b00 : vc), TW'(f), {AW{1'b0}}};
    endfunction

    task automatic run_cmd(input logic [AW-1:0] base, input int lines, input int grp,
                           input logic [1:0] vc, input bit allc, input int af_pct, input int rsp_pct);
        int total, nf, e_wr, e_grp, e_fi, seen, deliv, cyc, nlead, pick;
        bit exp_done, is_f;
        logic [HW-1:0] eh;
        logic [DW-1:0] ed;
        nf = (grp == 0 || lines == 0) ? 0 : (lines - 1) / grp;
        total = lines + nf;
        e_wr = 0; e_grp = 0; e_fi = 0; seen = 0; deliv = 0; cyc = 0;
        pend.delete();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_base = base; cmd_lines = CW'(lines); cmd_group = CW'(grp);
        cmd_vc = vc; cmd_all_vc = allc; tx_almost_full = 1'b0; rx_valid = 1'b0; rx_fence = 1'b0;
        #1;
        chk(cmd_ready == 1'b1, "R2", "cmd_ready before take", 64'(cmd_ready), 1);
        @(negedge clk);
        forever begin
            exp_done = (seen == total) && (deliv == total);
            tx_almost_full = (($urandom % 100) < af_pct);
            rx_valid = 1'b0; rx_fence = 1'b0;
            if (pend.size() > 0 && ($urandom % 100) < rsp_pct) begin
                nlead = 0;
                while (nlead < pend.size() && pend[nlead] == 1'b0) nlead++;
                if (nlead > 0) begin
                    pick = int'($urandom % nlead);
                    pend.delete(pick);
                    rx_fence = 1'b0;
                end else begin
                    void'(pend.pop_front());
                    rx_fence = 1'b1;
                end
                rx_valid = 1'b1;
            end
            // R2: a command offered while busy must change nothing
            cmd_valid = !exp_done && (($urandom % 6) == 0);
            cmd_base = AW'($urandom); cmd_lines = CW'($urandom); cmd_group = CW'($urandom);
            cmd_vc = 2'($urandom); cmd_all_vc = 1'($urandom);
            #1;
            chk(done == exp_done, "R7 R8", "done", 64'(done), 64'(exp_done));
            chk(busy == !exp_done, "R2", "busy", 64'(busy), 64'(!exp_done));
            chk(cmd_ready == exp_done, "R2", "cmd_ready", 64'(cmd_ready), 64'(exp_done));
            chk(tx_valid == ((seen < total) && !tx_almost_full), "R6", "tx_valid vs almost-full",
                64'(tx_valid), 64'((seen < total) && !tx_almost_full));
            if (tx_valid && seen < total) begin
                is_f = (grp != 0) && (e_grp == grp) && (e_wr < lines);
                if (is_f) begin
                    eh = exp_fence(e_fi, vc, allc);
                    ed = '0;
                    chk(tx_hdr == eh, "R4 R5", "fence header", 64'(tx_hdr), 64'(eh));
                    chk(tx_data == ed, "R4", "fence data", 64'(tx_data), 0);
                    e_fi++; e_grp = 0;
                end else begin
                    eh = exp_write(base, e_wr, vc);
                    ed = {{(DW-AW){1'b0}}, eh[AW-1:0]};
                    chk(tx_hdr == eh, "R3 R5", "write header", 64'(tx_hdr), 64'(eh));
                    chk(tx_data == ed, "R3", "write data", 64'(tx_data), 64'(ed[63:0]));
                    e_wr++; e_grp++;
                end
                pend.push_back(is_f);
                seen++;
            end
            if (rx_valid) deliv++;
            if (exp_done) break;
            cyc++;
            if (cyc > LIMIT) begin
                chk(1'b0, "R7", "watchdog expired", 64'(seen), 64'(total));
                break;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0; rx_valid = 1'b0; tx_almost_full = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0f3c));
        tx_almost_full = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tx_almost_full = 1'b0;
        #1;
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", 64'(tx_valid), 0);
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 64'(cmd_ready), 1);

        run_cmd(32'h0000_1000, 5, 2, 2'd1, 1'b0, 0, 100);   // R4 fences after 2 and 4
        run_cmd(32'h0000_2000, 4, 2, 2'd2, 1'b1, 30, 70);   // R4 no trailing fence, R5 all-channel
        run_cmd(32'h0000_3000, 6, 0, 2'd3, 1'b0, 20, 60);   // R4 group 0
        run_cmd(32'h0000_4000, 3, 7, 2'd1, 1'b1, 0, 100);   // R4 group larger than count
        run_cmd(32'h0000_5000, 0, 3, 2'd2, 1'b0, 0, 100);   // R7 zero lines
        run_cmd(32'h0000_6000, 1, 1, 2'd3, 1'b0, 50, 50);   // R4 single line
        run_cmd(32'h0000_7000, 8, 1, 2'd2, 1'b0, 70, 40);   // R6 heavy back-pressure
        run_cmd(32'hFFFF_FFFE, 4, 3, 2'd1, 1'b1, 10, 80);   // R3 address wrap
        run_cmd(32'h0010_0000, 300, 3, 2'd1, 1'b0, 25, 60); // R3 tag wrap
        for (int i = 0; i < 15; i++) begin
            run_cmd(AW'($urandom), int'($urandom % 81), int'($urandom % 11), 2'($urandom),
                    1'($urandom), int'(($urandom % 4) * 25), 30 + int'($urandom % 71));
        end
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule